// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block sits between a register port and a CAN frame transmitter. It holds three transmit mailboxes, each with an identifier word, a length code and eight payload bytes. It decides which pending mailbox goes to the transmitter next. When the transmitter is idle and at least one mailbox is pending, the scheduler latches its choice and raises a one-cycle start strobe. The contents of the chosen mailbox stay on the outputs until the attempt ends.

There are two ordering policies. The first serves mailboxes by number, lowest first. The second serves the mailbox whose identifier is numerically lowest, which is the same rule the bus uses for arbitration. The transmitter reports four events: arbitration won, arbitration lost, frame done and error. These events decide whether a mailbox's ready flag is cleared or the mailbox stays pending for another try. A configuration bit chooses whether a frame that lost arbitration is retried or dropped.

Top module: `can_tx_mbox_sched`

## Requirements
- R1: After reset no mailbox is pending. `tx_start` and `tx_busy` are 0, and no start occurs until a mailbox is made ready.
- R2: The write port addresses a field with `wr_field`: 0 is the identifier word, 1 is the length code in `wr_data[3:0]`, 2 is payload bytes 0..3 and 3 is payload bytes 4..7. An identifier word write loads ready from bit 31, the extended flag from bit 30, the remote flag from bit 29 and the identifier from bits 28..0. A standard identifier sits in bits 28..18. The selected mailbox presents these values on `tx_ident`, `tx_ext` and `tx_rtr`.
- R3: While idle, if any mailbox is pending, `tx_start` is high for exactly one cycle, starting the cycle after the ready flag is set. In that cycle `tx_mbox` and the frame outputs already describe the chosen mailbox.
- R4: With `cfg_prio_num` = 1, the pending mailbox with the lowest number is chosen.
- R5: With `cfg_prio_num` = 0, the pending mailbox with the lowest key is chosen. For an extended frame the key is its 29-bit identifier. For a standard frame the key is its 11 base bits followed by 18 zero bits, so bits 17..0 are ignored. On equal keys the lower mailbox number wins.
- R6: A done indication during transmission clears the mailbox's ready flag, and the mailbox is not started again.
- R7: If arbitration is lost while `cfg_auto_retx` = 1, the mailbox stays pending and is selected again under the current ordering.
- R8: If arbitration is lost while `cfg_auto_retx` = 0, the mailbox's ready flag is cleared and the frame is dropped.
- R9: An error indication ends the attempt and leaves the mailbox pending, whatever the value of `cfg_auto_retx`.
- R10: `tx_busy` is 1 only from the cycle after arbitration is won until done or error ends the attempt.
- R11: From start until the attempt ends, the frame outputs stay stable, and register writes to the mailbox in flight are ignored.
- R12: `tx_len` equals the length code limited to 8, so a code of 9..15 gives 8.
- R13: `tx_data` carries payload byte k in bits 8k+7..8k. Bytes 0..3 come from word field 2, low byte first, and bytes 4..7 come from field 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prio_num | input | 1 | 1: mailbox-number order, 0: lowest-identifier order |
| cfg_auto_retx | input | 1 | Retry after lost arbitration when 1 |
| wr_en | input | 1 | Register write strobe |
| wr_mbox | input | 2 | Target mailbox (0..2) |
| wr_field | input | 2 | Field select, see R2 |
| wr_data | input | 32 | Write data |
| txr_arb_won | input | 1 | Transmitter won arbitration (pulse) |
| txr_arb_lost | input | 1 | Transmitter lost arbitration (pulse) |
| txr_done | input | 1 | Frame sent successfully (pulse) |
| txr_error | input | 1 | Attempt aborted by an error (pulse) |
| tx_start | output | 1 | One-cycle start strobe to the transmitter |
| tx_mbox | output | 2 | Number of the selected mailbox |
| tx_ident | output | 29 | Identifier of the selected frame |
| tx_ext | output | 1 | Selected frame uses an extended identifier |
| tx_rtr | output | 1 | Selected frame is a remote request |
| tx_len | output | 4 | Payload length, limited to 8 |
| tx_data | output | 64 | Payload bytes, byte 0 in the low bits |
| tx_busy | output | 1 | Sending after arbitration was won |

## Verification
The assertions assume that the transmitter is well behaved. Each of its indications is a single-cycle pulse. Arbitration won or lost is reported only after a start, and done only after arbitration was won. Each assertion also assumes that the register port does not write a mailbox in the same cycle that the idle scheduler is choosing it. The bench follows these rules by waiting for `tx_start` before it pulses any transmitter event. It loads competing mailboxes only while another mailbox is in flight, which also means several mailboxes are pending at the moment an ordering decision is made.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

    localparam int ID_W      = 29;
    localparam int BASE_W    = 11;
    localparam int EXT_W     = ID_W - BASE_W;
    localparam int PAY_BYTES = 8;
    localparam int PAY_W     = PAY_BYTES * 8;
    localparam int LEN_W     = 4;

    typedef enum logic [1:0] {
        FLD_IDENT = 2'd0,
        FLD_LEN   = 2'd1,
        FLD_LO    = 2'd2,
        FLD_HI    = 2'd3
    } fld_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_SEND = 2'd2
    } sched_st_e;

    typedef struct packed {
        logic             ready;
        logic             ext;
        logic             rtr;
        logic [ID_W-1:0]  ident;
        logic [LEN_W-1:0] dlc;
        logic [PAY_W-1:0] data;
    } mbox_t;

    // Ordering key: a standard frame keeps only its base bits, placed on top.
    function automatic logic [ID_W-1:0] prio_key(input logic ext, input logic [ID_W-1:0] id);
        if (ext)
            return id;
        return {id[ID_W-1:EXT_W], {EXT_W{1'b0}}};
    endfunction

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] dlc);
        if (dlc > LEN_W'(PAY_BYTES))
            return LEN_W'(PAY_BYTES);
        return dlc;
    endfunction

endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
    import can_txmb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_field,
    input  logic [31:0] wr_data,
    input  logic        clr_ready,
    output mbox_t       mbox
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mbox <= '0;
        end else if (clr_ready) begin
            mbox.ready <= 1'b0;
        end else if (wr_en) begin
            case (fld_e'(wr_field))
                FLD_IDENT: begin
                    mbox.ready <= wr_data[31];
                    mbox.ext   <= wr_data[30];
                    mbox.rtr   <= wr_data[29];
                    mbox.ident <= wr_data[ID_W-1:0];
                end
                FLD_LEN: mbox.dlc          <= wr_data[LEN_W-1:0];
                FLD_LO:  mbox.data[31:0]   <= wr_data;
                FLD_HI:  mbox.data[63:32]  <= wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/can_txmb_pick.sv
module can_txmb_pick
    import can_txmb_pkg::*;
#(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  mbox_t [N-1:0] slots,
    input  logic          prio_num,
    output logic          valid,
    output logic [IW-1:0] idx
);

    logic [ID_W-1:0] best;
    logic [ID_W-1:0] key;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '1;
        key   = '0;
        for (int i = 0; i < N; i++) begin
            key = prio_key(slots[i].ext, slots[i].ident);
            if (slots[i].ready && (!valid || (!prio_num && key < best))) begin
                valid = 1'b1;
                idx   = IW'(i);
                best  = key;
            end
        end
    end

endmodule

// File: rtl/can_txmb_ctrl.sv
module can_txmb_ctrl
    import can_txmb_pkg::*;
#(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cand_valid,
    input  logic [IW-1:0] cand_idx,
    input  logic          auto_retx,
    input  logic          arb_won,
    input  logic          arb_lost,
    input  logic          done,
    input  logic          error,
    output logic [IW-1:0] sel,
    output logic          start,
    output logic          inflight,
    output logic          busy,
    output logic [N-1:0]  clr
);

    sched_st_e st_q;
    logic      drop_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            sel   <= '0;
            start <= 1'b0;
        end else begin
            start <= 1'b0;
            case (st_q)
                ST_IDLE: if (cand_valid) begin
                    sel   <= cand_idx;
                    start <= 1'b1;
                    st_q  <= ST_ARB;
                end
                ST_ARB: begin
                    if (error || arb_lost) st_q <= ST_IDLE;
                    else if (arb_won)      st_q <= ST_SEND;
                end
                ST_SEND: if (done || error) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        drop_now = 1'b0;
        if (st_q == ST_SEND && done && !error)
            drop_now = 1'b1;
        if (st_q == ST_ARB && arb_lost && !error && !auto_retx)
            drop_now = 1'b1;
        for (int i = 0; i < N; i++)
            clr[i] = drop_now && (sel == IW'(i));
    end

    assign inflight = (st_q != ST_IDLE);
    assign busy     = (st_q == ST_SEND);

endmodule

// File: rtl/can_tx_mbox_sched.sv
module can_tx_mbox_sched
    import can_txmb_pkg::*;
#(
    parameter int NUM_MBOX = 3,
    localparam int IDX_W   = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_prio_num,
    input  logic              cfg_auto_retx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_mbox,
    input  logic [1:0]        wr_field,
    input  logic [31:0]       wr_data,
    input  logic              txr_arb_won,
    input  logic              txr_arb_lost,
    input  logic              txr_done,
    input  logic              txr_error,
    output logic              tx_start,
    output logic [IDX_W-1:0]  tx_mbox,
    output logic [ID_W-1:0]   tx_ident,
    output logic              tx_ext,
    output logic              tx_rtr,
    output logic [LEN_W-1:0]  tx_len,
    output logic [PAY_W-1:0]  tx_data,
    output logic              tx_busy
);

    mbox_t [NUM_MBOX-1:0] slots;
    logic  [NUM_MBOX-1:0] clr;
    logic                 cand_valid;
    logic  [IDX_W-1:0]    cand_idx;
    logic  [IDX_W-1:0]    sel;
    logic                 inflight;
    mbox_t                cur;

    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_slot
        logic lock;
        assign lock = inflight && (sel == IDX_W'(g));
        can_txmb_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_en && (wr_mbox == IDX_W'(g)) && !lock),
            .wr_field  (wr_field),
            .wr_data   (wr_data),
            .clr_ready (clr[g]),
            .mbox      (slots[g])
        );
    end

    can_txmb_pick #(.N(NUM_MBOX), .IW(IDX_W)) u_pick (
        .slots    (slots),
        .prio_num (cfg_prio_num),
        .valid    (cand_valid),
        .idx      (cand_idx)
    );

    can_txmb_ctrl #(.N(NUM_MBOX), .IW(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cand_valid (cand_valid),
        .cand_idx   (cand_idx),
        .auto_retx  (cfg_auto_retx),
        .arb_won    (txr_arb_won),
        .arb_lost   (txr_arb_lost),
        .done       (txr_done),
        .error      (txr_error),
        .sel        (sel),
        .start      (tx_start),
        .inflight   (inflight),
        .busy       (tx_busy),
        .clr        (clr)
    );

    always_comb begin
        cur = '0;
        for (int i = 0; i < NUM_MBOX; i++)
            if (sel == IDX_W'(i)) cur = slots[i];
    end

    assign tx_mbox  = sel;
    assign tx_ident = cur.ident;
    assign tx_ext   = cur.ext;
    assign tx_rtr   = cur.rtr;
    assign tx_len   = clamp_len(cur.dlc);
    assign tx_data  = cur.data;

endmodule

// File: rtl/can_txmb_chk.sv
module can_txmb_chk
    import can_txmb_pkg::*;
#(
    parameter int IW = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_start,
    input logic             tx_busy,
    input logic             inflight,
    input logic             txr_arb_won,
    input logic [IW-1:0]    tx_mbox,
    input logic [ID_W-1:0]  tx_ident,
    input logic [PAY_W-1:0] tx_data,
    input logic [LEN_W-1:0] tx_len
);

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);                                             // R3

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> !$past(inflight));                                      // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (inflight && $past(inflight)) |-> ($stable(tx_ident) && $stable(tx_mbox) && $stable(tx_data))); // R11

    AST_LEN_CAP: assert property (@(posedge clk) disable iff (rst)
        tx_len <= LEN_W'(PAY_BYTES));                                        // R12

    AST_BUSY_AFTER_WIN: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> $past(txr_arb_won));                              // R10

    AST_BUSY_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
        tx_busy |-> inflight);                                               // R10

endmodule

bind can_tx_mbox_sched can_txmb_chk #(.IW(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_start    (tx_start),
    .tx_busy     (tx_busy),
    .inflight    (inflight),
    .txr_arb_won (txr_arb_won),
    .tx_mbox     (tx_mbox),
    .tx_ident    (tx_ident),
    .tx_data     (tx_data),
    .tx_len      (tx_len)
);

// File: tb/can_tx_mbox_sched_tb.sv
module can_tx_mbox_sched_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_prio_num = 1'b1;
    logic        cfg_auto_retx = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_mbox = '0;
    logic [1:0]  wr_field = '0;
    logic [31:0] wr_data = '0;
    logic        txr_arb_won = 1'b0;
    logic        txr_arb_lost = 1'b0;
    logic        txr_done = 1'b0;
    logic        txr_error = 1'b0;
    logic        tx_start;
    logic [1:0]  tx_mbox;
    logic [28:0] tx_ident;
    logic        tx_ext;
    logic        tx_rtr;
    logic [3:0]  tx_len;
    logic [63:0] tx_data;
    logic        tx_busy;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    can_tx_mbox_sched u_dut (
        .clk(clk), .rst(rst), .cfg_prio_num(cfg_prio_num), .cfg_auto_retx(cfg_auto_retx),
        .wr_en(wr_en), .wr_mbox(wr_mbox), .wr_field(wr_field), .wr_data(wr_data),
        .txr_arb_won(txr_arb_won), .txr_arb_lost(txr_arb_lost), .txr_done(txr_done),
        .txr_error(txr_error), .tx_start(tx_start), .tx_mbox(tx_mbox), .tx_ident(tx_ident),
        .tx_ext(tx_ext), .tx_rtr(tx_rtr), .tx_len(tx_len), .tx_data(tx_data), .tx_busy(tx_busy)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] mb, input logic [1:0] fld, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_mbox = mb; wr_field = fld; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [1:0] mb, input logic [28:0] id, input bit ext, input bit rtr,
                        input logic [3:0] dlc, input logic [31:0] lo, input logic [31:0] hi);
        write_reg(mb, 2'd1, {28'd0, dlc});
        write_reg(mb, 2'd2, lo);
        write_reg(mb, 2'd3, hi);
        write_reg(mb, 2'd0, {1'b1, ext, rtr, id});
    endtask

    task automatic wait_start(input int maxc, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (tx_start) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    // which: 0 won, 1 lost, 2 done, 3 error
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: txr_arb_won  = 1'b1;
            1: txr_arb_lost = 1'b1;
            2: txr_done     = 1'b1;
            default: txr_error = 1'b1;
        endcase
        @(negedge clk);
        txr_arb_won = 1'b0; txr_arb_lost = 1'b0; txr_done = 1'b0; txr_error = 1'b0;
    endtask

    task automatic finish_frame();
        pulse(0);
        pulse(2);
    endtask

    task automatic expect_start(input logic [1:0] mb, input string req);
        bit seen;
        wait_start(10, seen);
        check(seen, req, {63'd0, seen}, 64'd1);
        check(tx_mbox == mb, req, {62'd0, tx_mbox}, {62'd0, mb});
    endtask

    task automatic expect_quiet(input string req);
        bit seen;
        wait_start(12, seen);
        check(!seen, req, {63'd0, seen}, 64'd0);
    endtask

    task automatic t_reset();
        check(!tx_start && !tx_busy, "R1 outputs idle", {62'd0, tx_start, tx_busy}, 64'd0);
        expect_quiet("R1 no start without pending mailbox");
    endtask

    task automatic t_basic();
        bit seen;
        cfg_prio_num = 1'b1; cfg_auto_retx = 1'b1;
        load(2'd0, 29'h0ABCDE12, 1'b1, 1'b0, 4'd5, 32'h44332211, 32'h88776655);
        wait_start(5, seen);
        check(seen, "R3 start after ready", {63'd0, seen}, 64'd1);
        check(tx_mbox == 2'd0, "R3 chosen mailbox", {62'd0, tx_mbox}, 64'd0);
        check(tx_ident == 29'h0ABCDE12, "R2 identifier", {35'd0, tx_ident}, 64'h0ABCDE12);
        check(tx_ext && !tx_rtr, "R2 flags", {62'd0, tx_ext, tx_rtr}, 64'd2);
        check(tx_len == 4'd5, "R12 length in range", {60'd0, tx_len}, 64'd5);
        check(tx_data == 64'h8877665544332211, "R13 payload packing", tx_data, 64'h8877665544332211);
        @(negedge clk);
        check(!tx_start, "R3 single-cycle strobe", {63'd0, tx_start}, 64'd0);
        check(!tx_busy, "R10 not busy before win", {63'd0, tx_busy}, 64'd0);
        pulse(0);
        check(tx_busy, "R10 busy after win", {63'd0, tx_busy}, 64'd1);
        write_reg(2'd0, 2'd0, {3'b111, 29'h1});
        check(tx_ident == 29'h0ABCDE12, "R11 write to in-flight ignored", {35'd0, tx_ident}, 64'h0ABCDE12);
        pulse(2);
        check(!tx_busy, "R10 busy ends at done", {63'd0, tx_busy}, 64'd0);
        expect_quiet("R6 done clears ready, R11 ignored write left it clear");
    endtask

    task automatic t_clamp();
        load(2'd1, 29'h55, 1'b1, 1'b1, 4'hF, 32'h0, 32'h0);
        expect_start(2'd1, "R12 start");
        check(tx_len == 4'd8, "R12 clamp to 8", {60'd0, tx_len}, 64'd8);
        check(tx_rtr, "R2 remote flag", {63'd0, tx_rtr}, 64'd1);
        finish_frame();
    endtask

    task automatic t_number_order();
        cfg_prio_num = 1'b1; cfg_auto_retx = 1'b1;
        load(2'd2, 29'h5, 1'b1, 1'b0, 4'd1, 32'h0, 32'h0);
        expect_start(2'd2, "R4 first start");
        load(2'd0, 29'h1FFFFFFF, 1'b1, 1'b0, 4'd1, 32'h0, 32'h0);
        load(2'd1, 29'h1000, 1'b1, 1'b0, 4'd1, 32'h0, 32'h0);
        pulse(1);
        expect_start(2'd0, "R4 number order picks mailbox 0");
        finish_frame();
        expect_start(2'd1, "R4 then mailbox 1");
        finish_frame();
        expect_start(2'd2, "R7 lost frame retried");
        finish_frame();
        expect_quiet("R6 all served");
    endtask

    task automatic t_id_order();
        cfg_prio_num = 1'b0; cfg_auto_retx = 1'b1;
        load(2'd0, 29'h100, 1'b1, 1'b0, 4'd2, 32'h0, 32'h0);
        expect_start(2'd0, "R5 first start");
        load(2'd1, {11'h000, 18'h3FFFF}, 1'b0, 1'b0, 4'd2, 32'h0, 32'h0);
        load(2'd2, 29'h50, 1'b1, 1'b0, 4'd2, 32'h0, 32'h0);
        pulse(1);
        expect_start(2'd1, "R5 standard key uses base bits only");
        finish_frame();
        expect_start(2'd2, "R5 next lowest identifier");
        finish_frame();
        expect_start(2'd0, "R5 highest identifier last");
        finish_frame();
        // tie between mailboxes 1 and 2
        load(2'd2, 29'h77, 1'b1, 1'b0, 4'd1, 32'h0, 32'h0);
        expect_start(2'd2, "R5 tie setup");
        load(2'd0, 29'h999, 1'b1, 1'b0, 4'd1, 32'h0, 32'h0);
        load(2'd1, 29'h77, 1'b1, 1'b0, 4'd1, 32'h0, 32'h0);
        pulse(1);
        expect_start(2'd1, "R5 tie goes to lower number");
        finish_frame();
        expect_start(2'd2, "R7 tied loser retried");
        finish_frame();
        expect_start(2'd0, "R5 remaining mailbox");
        finish_frame();
        expect_quiet("R6 queue empty");
    endtask

    task automatic t_drop();
        cfg_prio_num = 1'b1; cfg_auto_retx = 1'b0;
        load(2'd0, 29'h33, 1'b1, 1'b0, 4'd1, 32'h0, 32'h0);
        expect_start(2'd0, "R8 start");
        pulse(1);
        expect_quiet("R8 dropped after lost arbitration");
    endtask

    task automatic t_error();
        cfg_prio_num = 1'b1; cfg_auto_retx = 1'b0;
        load(2'd1, 29'h44, 1'b1, 1'b0, 4'd1, 32'h0, 32'h0);
        expect_start(2'd1, "R9 start");
        pulse(0);
        pulse(3);
        check(!tx_busy, "R10 busy ends at error", {63'd0, tx_busy}, 64'd0);
        expect_start(2'd1, "R9 error keeps mailbox pending");
        finish_frame();
        expect_quiet("R6 cleared after retry");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_clamp();
        t_number_order();
        t_id_order();
        t_drop();
        t_error();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule